// File: doc/BRIEF.md
# Staged Clock-Enable Divider Bank

This block sits after a frequency multiplier and turns the source clock into seven divided clock-enable pulse trains: one ahead of the multiplier (pre), one after it (post), and five output-domain dividers. Software programs each ratio through a small memory-mapped register port (address, write data, write strobe, read data). New ratios wait in staged (pending) registers and change nothing on the outputs. A command write makes them all live together. The outputs are single-cycle clock enables, not gated clocks.

A command sequencer runs the switch-over. It has three states. In `ST_IDLE` it waits for a command. On a valid command it moves to `ST_ALIGN`. `ST_ALIGN` lasts one cycle and issues a single load pulse: every divider copies its staged value into its active setting and restarts its counter at zero, so all dividers share one phase reference. The sequencer then always moves to `ST_HOLD` and stays there for `BUSY_CYC` cycles. When the hold count reaches its limit it returns to `ST_IDLE`. The status flag reads 1 in both `ST_ALIGN` and `ST_HOLD`, and software polls it before it goes on. A separate multiplier register is stored and read back but drives nothing.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, every divider is enabled with ratio 1, so `div_ce` is all ones. Each divider register reads 0x0000_8000, the multiplier register reads 0 and the status register reads 0.
- R2: A divider register keeps the ratio minus one in bits [4:0] and the enable in bit 15. Reads return exactly those fields of the last write, and every other bit reads 0.
- R3: Writes to divider registers do not change `div_ce` until a command is accepted.
- R4: A write to offset 0x138 with bit 0 set, made while the status is clear, starts a transition. Bit 0 of offset 0x13C then reads 1 from the cycle after the write for `BUSY_CYC`+1 cycles, and then reads 0.
- R5: At the alignment point, all staged settings load in the same cycle and every counter restarts. An enabled divider with ratio N pulses in the first cycle after the load and then once every N cycles, with the pulses of all dividers aligned.
- R6: A divider whose enable bit is 0 drives a constant 1 on its `div_ce` bit, and its counter is held.
- R7: A command written while the status reads 1 is ignored, and the busy period is not extended.
- R8: Offset 0x110 holds an 8-bit multiplier minus one. Higher write bits are dropped, and the register has no effect on `div_ce`.
- R9: Unmapped offsets read 0 and ignore writes. Offset 0x138 reads 0. A write to 0x138 with bit 0 clear starts nothing.
- R10: The `div_ce` bit order is: bit 0 pre (0x114), bit 1 post (0x128), and bits 2 to 6 for dividers 1 to 5 (0x118, 0x11C, 0x120, 0x160, 0x164).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| div_ce | output | 7 | Divided clock-enable pulses, one per divider |

## Verification
The bench first writes a new ratio and holds off the command. A design that leaks staged values into the active counters would lose the constant-high pattern on that output before the command arrives. It sends a second command while the first is still busy. A design that re-arms would hold the status high past `BUSY_CYC`+1 cycles or reload the counters a second time. It loads two dividers that were running at different phases and checks that they pulse in the same cycle after the load, which catches a load that skips the counter restart. It also covers the largest ratio, a disabled divider, every register offset, and unmapped or aliased writes, which catches decode slips and a wrong bit-to-output mapping.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int NDIV    = 7;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int RATIO_W = 5;
    localparam int EN_BIT  = 15;
    localparam int MULT_W  = 8;

    localparam logic [ADDR_W-1:0] OFF_MULT = 12'h110;
    localparam logic [ADDR_W-1:0] OFF_CMD  = 12'h138;
    localparam logic [ADDR_W-1:0] OFF_STAT = 12'h13C;

    typedef struct packed {
        logic               en;
        logic [RATIO_W-1:0] m1;
    } div_cfg_t;

    localparam div_cfg_t CFG_RESET = '{en: 1'b1, m1: '0};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_HOLD
    } seq_state_t;

    // Register offset of each divider, in div_ce bit order.
    function automatic logic [ADDR_W-1:0] div_offset(input int idx);
        case (idx)
            0:       return 12'h114;
            1:       return 12'h128;
            2:       return 12'h118;
            3:       return 12'h11C;
            4:       return 12'h120;
            5:       return 12'h160;
            default: return 12'h164;
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    input  logic              busy_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              go_o,
    output div_cfg_t          pend_o [NDIV]
);

    logic [MULT_W-1:0] mult_q;

    assign go_o = we_i && (addr_i == OFF_CMD) && wdata_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mult_q <= '0;
            for (int i = 0; i < NDIV; i++) pend_o[i] <= CFG_RESET;
        end else if (we_i) begin
            if (addr_i == OFF_MULT) mult_q <= wdata_i[MULT_W-1:0];
            for (int i = 0; i < NDIV; i++) begin
                if (addr_i == div_offset(i)) begin
                    pend_o[i].en <= wdata_i[EN_BIT];
                    pend_o[i].m1 <= wdata_i[RATIO_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == OFF_MULT) rdata_o[MULT_W-1:0] = mult_q;
        if (addr_i == OFF_STAT) rdata_o[0] = busy_i;
        for (int i = 0; i < NDIV; i++) begin
            if (addr_i == div_offset(i)) begin
                rdata_o[EN_BIT]      = pend_o[i].en;
                rdata_o[RATIO_W-1:0] = pend_o[i].m1;
            end
        end
    end

    // A command write shows up as busy on the status offset one cycle later.
    p_go_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && !busy_i) |=> busy_i);

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
    import clkdiv_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o,
    output logic load_o
);

    localparam int HCNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [HCNT_W-1:0] HOLD_LAST = HCNT_W'(BUSY_CYC - 1);

    seq_state_t        state_q, state_d;
    logic [HCNT_W-1:0] hcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            hcnt_q  <= (state_q == ST_HOLD) ? hcnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go_i) state_d = ST_ALIGN;
            ST_ALIGN: state_d = ST_HOLD;
            ST_HOLD:  if (hcnt_q == HOLD_LAST) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o = (state_q != ST_IDLE);
        load_o = (state_q == ST_ALIGN);
    end

    p_hold_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (hcnt_q <= HOLD_LAST));
    p_no_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (state_q != ST_ALIGN));
    p_single_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  div_cfg_t cfg_i,
    output logic     ce_o
);

    div_cfg_t           act_q;
    logic [RATIO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= CFG_RESET;
            cnt_q <= '0;
        end else if (load_i) begin
            act_q <= cfg_i;
            cnt_q <= '0;
        end else if (act_q.en) begin
            cnt_q <= (cnt_q == act_q.m1) ? '0 : cnt_q + 1'b1;
        end
    end

    assign ce_o = !act_q.en || (cnt_q == '0);

    p_staged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(act_q));
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == '0));
    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_q.en |-> (cnt_q <= act_q.m1));
    p_held_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q.en && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NDIV-1:0]   div_ce
);

    logic     go, busy, load;
    div_cfg_t pend [NDIV];

    clkdiv_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .we_i    (reg_we),
        .busy_i  (busy),
        .rdata_o (reg_rdata),
        .go_o    (go),
        .pend_o  (pend)
    );

    clkdiv_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .busy_o (busy),
        .load_o (load)
    );

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        clkdiv_counter u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .cfg_i  (pend[g]),
            .ce_o   (div_ce[g])
        );
    end

endmodule

// File: tb/test_clkdiv_bank.sv
module test_clkdiv_bank;
    import clkdiv_pkg::*;

    localparam int BUSY_CYC = 4;

    typedef struct packed {
        logic [11:0] addr;
        int          idx;
        logic        en;
        int          ratio;
        logic [7:0]  exp;   // bit k = expected ce in cycle k after the load
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{12'h114, 0, 1'b1, 3,  8'h49},
        '{12'h128, 1, 1'b1, 2,  8'h55},
        '{12'h118, 2, 1'b1, 4,  8'h11},
        '{12'h11C, 3, 1'b1, 5,  8'h21},
        '{12'h120, 4, 1'b0, 4,  8'hFF},
        '{12'h160, 5, 1'b1, 8,  8'h01},
        '{12'h164, 6, 1'b1, 32, 8'h01},
        '{12'h114, 0, 1'b1, 1,  8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [6:0]  div_ce;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    clkdiv_bank #(.BUSY_CYC(BUSY_CYC)) i_clkdiv_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .div_ce    (div_ce)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] enc(input logic en, input int ratio);
        return (32'(en) << 15) | 32'(ratio - 1);
    endfunction

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  got;
        int          mism;
        int          busy_n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk("R1 ce", 32'(div_ce), 32'h7F);
        rd(OFF_STAT, v); chk("R1 status", v, 0);
        rd(12'h114, v);  chk("R1 divreg", v, 32'h8000);
        rd(12'h164, v);  chk("R1 divreg5", v, 32'h8000);
        rd(OFF_MULT, v); chk("R1 mult", v, 0);

        // R3 staged write stays invisible before the command
        wr(12'h118, enc(1'b1, 4));
        mism = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #1;
            if (div_ce[2] !== 1'b1) mism++;
        end
        chk("R3 no change before GO", mism, 0);

        // R4 busy timing
        wr(OFF_CMD, 32'h1);
        busy_n = 0;
        for (int k = 0; k < 8; k++) begin
            rd(OFF_STAT, v);
            if (v[0]) busy_n++;
            @(negedge clk);
        end
        chk("R4 busy cycles", busy_n, BUSY_CYC + 1);
        rd(OFF_STAT, v); chk("R4 busy clear", v, 0);

        // Table walk: R2 readback, R5/R6/R10 pulse patterns
        foreach (TBL[n]) begin
            wr(TBL[n].addr, enc(TBL[n].en, TBL[n].ratio) | 32'h7FE0_0000);
            rd(TBL[n].addr, v);
            chk("R2 readback", v, enc(TBL[n].en, TBL[n].ratio));
            wr(OFF_CMD, 32'h1);
            for (int k = 0; k < 8; k++) begin
                @(negedge clk); #1;
                got[k] = div_ce[TBL[n].idx];
            end
            chk(TBL[n].en ? "R5 R10 pattern" : "R6 R10 pass-through",
                32'(got), 32'(TBL[n].exp));
            repeat (3) @(negedge clk);
        end

        // R5 alignment of two dividers with different prior phase
        wr(12'h118, enc(1'b1, 3));
        repeat (2) @(negedge clk);
        wr(12'h11C, enc(1'b1, 3));
        wr(OFF_CMD, 32'h1);
        @(negedge clk); #1;
        chk("R5 aligned k0", 32'(div_ce[3:2]), 32'h3);
        @(negedge clk); #1;
        chk("R5 aligned k1", 32'(div_ce[3:2]), 32'h0);
        repeat (2) @(negedge clk); #1;
        chk("R5 aligned k3", 32'(div_ce[3:2]), 32'h3);
        repeat (4) @(negedge clk);

        // R7 command while busy is ignored
        wr(OFF_CMD, 32'h1);
        reg_addr = OFF_CMD; reg_wdata = 32'h1; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        busy_n = 0;
        for (int k = 0; k < 6; k++) begin
            rd(OFF_STAT, v);
            if (v[0]) busy_n++;
            @(negedge clk);
        end
        chk("R7 busy not extended", busy_n, BUSY_CYC);

        // R8 multiplier register
        wr(OFF_MULT, 32'h1AB);
        rd(OFF_MULT, v); chk("R8 mult 8 bits", v, 32'hAB);
        rd(12'h114, v);  chk("R8 divreg untouched", v, enc(1'b1, 1));
        @(negedge clk); #1;
        chk("R8 ce pre unaffected", 32'(div_ce[0]), 1);

        // R9 unmapped offsets and command readback
        wr(12'h200, 32'hFFFF_FFFF);
        rd(12'h200, v); chk("R9 unmapped read", v, 0);
        wr(12'h014, 32'h0000_0003);
        rd(12'h114, v); chk("R9 alias ignored", v, enc(1'b1, 1));
        rd(OFF_CMD, v); chk("R9 cmd reads 0", v, 0);
        wr(OFF_CMD, 32'h2);
        rd(OFF_STAT, v); chk("R9 cmd bit0 clear no start", v, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule